// File: doc/BRIEF.md
# System Control Register Block

This block is a memory-mapped file of system control registers on a simple 32-bit bus. The bus carries a byte offset, whose low two bits are ignored, along with separate read and write strobes. It holds the registers that configure clocks, gate peripheral clocks, record reset causes and set brown-out thresholds. It also holds two user-data words that are loaded from a 48-bit input.

A small interrupt unit keeps three things: a 7-bit raw status, a mask, and a masked view. The masked view clears raw bits when ones are written to it. The interrupt unit drives one registered, level-sensitive interrupt line.

The clock-configuration register feeds two outputs. One is a clock-scale output. The other is a PLL-configuration readback computed from a crystal-select field and a device-family input. A write that powers the PLL up, by clearing the power-down bit, posts a status event. Accesses to offsets that are not mapped read as zero and pulse an error output.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the following values hold:
  - offset 0x030 reads 0x7ffd and offset 0x060 reads 0x078e3ac0.
  - offsets 0x100, 0x110 and 0x120 read 1, and the other gating offsets read 0.
  - raw status, mask and masked view read 0, and irq_o is low.
- R2: Writes keep only the low bits of narrow registers: 16 bits at 0x030, 5 bits at 0x034, 6 bits at 0x05c and 7 bits at the mask (0x054). Offsets 0x150, 0x160 and all gating registers keep all 32 bits.
- R3: Nine 32-bit clock-gating registers sit at 0x100/0x104/0x108 (run), 0x110/0x114/0x118 (sleep) and 0x120/0x124/0x128 (deep sleep). Each one reads back its own value. Offsets 0x10c and 0x130 are unmapped.
- R4: A write to 0x060 sets raw status bit 6 only when the stored bit 13 was 1 and the written bit 13 is 0. A write that leaves bit 13 at 1, or that writes 0 over a 0, posts nothing.
- R5: Offset 0x058 reads raw AND mask, and writing ones there clears the matching raw bits. Raw status reads at 0x050, and writes to 0x050 are ignored.
- R6: irq_o is a registered OR of (raw AND mask). It reflects a write in the cycle after that write.
- R7: clk_scale_o equals 5 × (clock-configuration bits [26:23] + 1).
- R8: Offset 0x064 reads a PLL entry indexed by i = clock-configuration bits [9:6]. For family_i = 0 the entry is ((i+1)·3)<<5 | i[1:0]. For family_i = 1 it is (2i+8)<<5 | i[3:2]. Writes to 0x064 are ignored.
- R9: Offsets 0x1e0 and 0x1e4 read user_data_i[23:0] and user_data_i[47:24] zero-extended, low byte first. Both are captured on the first clock after reset. Later input changes and writes are ignored.
- R10: An access to an unmapped offset reads 0 and pulses err_o high for one cycle, in the cycle after the access. Mapped accesses leave err_o low, and an unmapped write changes no register.
- R11: rdata_o takes the addressed value in the cycle after rd_i and holds it while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte offset, bits [1:0] ignored |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| family_i | input | 1 | Selects the PLL table |
| user_data_i | input | 48 | User-data bytes, low byte first |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Unmapped-access pulse |
| irq_o | output | 1 | Level interrupt |
| clk_scale_o | output | 7 | Derived clock scale |

## Verification
The hardest condition to reach is the PLL power-up event. It needs a stored bit 13 of 1 followed by a write that clears it, and every later write changes the history the next write is judged against. The stimulus first rewrites the register with bit 13 held high and confirms that no status appears. It then clears the bit to post the event, and writes 0 over 0 to show that no second event follows. Random writes to the plain registers, mixed with gating-bank boundary offsets, are checked against a bench model of each field width.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_BOR, SEL_LDO, SEL_RAW, SEL_MASK, SEL_MIS, SEL_RSTC,
    SEL_CLK, SEL_PLL, SEL_GATE, SEL_VCLR, SEL_LDOARST, SEL_USER0, SEL_USER1
  } sel_e;

  function automatic logic [31:0] pll_entry(input logic fam, input logic [3:0] idx);
    logic [31:0] mult, pre;
    if (!fam) begin
      mult = (32'(idx) + 32'd1) * 32'd3;
      pre  = 32'(idx[1:0]);
    end else begin
      mult = 32'(idx) * 32'd2 + 32'd8;
      pre  = 32'(idx[3:2]);
    end
    return (mult << 5) | pre;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned GROUPS    = 3,
  parameter int unsigned PER_GROUP = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic [1:0]        grp_o,
  output logic [1:0]        idx_o
);
  localparam int unsigned WW = ADDR_W - 2;
  logic [WW-1:0] word;

  assign word  = addr_i[ADDR_W-1:2];
  assign grp_o = word[3:2];
  assign idx_o = word[1:0];

  always_comb begin
    sel_o = SEL_NONE;
    case (word)
      WW'(10'h00c): sel_o = SEL_BOR;
      WW'(10'h00d): sel_o = SEL_LDO;
      WW'(10'h014): sel_o = SEL_RAW;
      WW'(10'h015): sel_o = SEL_MASK;
      WW'(10'h016): sel_o = SEL_MIS;
      WW'(10'h017): sel_o = SEL_RSTC;
      WW'(10'h018): sel_o = SEL_CLK;
      WW'(10'h019): sel_o = SEL_PLL;
      WW'(10'h054): sel_o = SEL_VCLR;
      WW'(10'h058): sel_o = SEL_LDOARST;
      WW'(10'h078): sel_o = SEL_USER0;
      WW'(10'h079): sel_o = SEL_USER1;
      default: begin
        if (word[WW-1:4] == (WW-4)'(6'h04) &&
            32'(word[3:2]) < GROUPS && 32'(word[1:0]) < PER_GROUP)
          sel_o = SEL_GATE;
      end
    endcase
  end
endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, raw_d, mask_q, mask_d;
  logic         irq_q;

  always_comb begin
    raw_d  = (raw_q & ~(clr_we_i ? wdata_i : '0)) | set_i;
    mask_d = mask_we_i ? wdata_i : mask_q;
  end

  // irq follows next state so it lands one cycle after the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sysctl_clkcfg.sv
module sysctl_clkcfg
  import sysctl_pkg::*;
#(
  parameter int unsigned   DW      = 32,
  parameter int unsigned   SCALE_W = 7,
  parameter logic [DW-1:0] RST_VAL = 32'h078e3ac0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               family_i,
  output logic [DW-1:0]      cfg_o,
  output logic [DW-1:0]      pll_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic               pll_evt_o
);
  localparam int unsigned PWRDN_BIT = 13;
  localparam int unsigned XTAL_LO   = 6;
  localparam int unsigned DIV_LO    = 23;

  logic [DW-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_VAL;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign pll_evt_o = we_i & cfg_q[PWRDN_BIT] & ~wdata_i[PWRDN_BIT];
  assign scale_o   = SCALE_W'(5 * (32'(cfg_q[DIV_LO+3:DIV_LO]) + 1));
  assign pll_o     = DW'(pll_entry(family_i, cfg_q[XTAL_LO+3:XTAL_LO]));
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/sysctl_gate_bank.sv
module sysctl_gate_bank #(
  parameter int unsigned GROUPS    = 3,
  parameter int unsigned PER_GROUP = 3,
  parameter int unsigned DW        = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    grp_i,
  input  logic [1:0]    idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] gate_q [GROUPS][PER_GROUP];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < PER_GROUP; i++) begin : g_reg
      localparam logic [DW-1:0] RST = (i == 0) ? DW'(1) : '0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q[g][i] <= RST;
        else if (we_i && 32'(grp_i) == g && 32'(idx_i) == i) gate_q[g][i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < GROUPS; g++)
      for (int i = 0; i < PER_GROUP; i++)
        if (32'(grp_i) == g && 32'(idx_i) == i) rdata_o = gate_q[g][i];
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DW        = 32,
  parameter int unsigned IRQ_W     = 7,
  parameter int unsigned GROUPS    = 3,
  parameter int unsigned PER_GROUP = 3,
  parameter int unsigned BOR_W     = 16,
  parameter int unsigned LDO_W     = 5,
  parameter int unsigned RSTC_W    = 6,
  parameter int unsigned USER_W    = 48,
  parameter int unsigned SCALE_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               family_i,
  input  logic [USER_W-1:0]  user_data_i,
  output logic [DW-1:0]      rdata_o,
  output logic               err_o,
  output logic               irq_o,
  output logic [SCALE_W-1:0] clk_scale_o
);
  localparam int unsigned    HALF_W  = USER_W / 2;
  localparam int unsigned    PLL_BIT = 6;
  localparam logic [BOR_W-1:0] BOR_RST = BOR_W'(16'h7ffd);

  sel_e            sel;
  logic [1:0]      grp, idx;
  logic [IRQ_W-1:0] raw_w, mask_w, set_w;
  logic            pll_evt;
  logic [DW-1:0]   cfg_w, pll_w, gate_rd, rd_val;

  logic [BOR_W-1:0]  bor_q;
  logic [LDO_W-1:0]  ldo_q;
  logic [RSTC_W-1:0] rstc_q;
  logic [DW-1:0]     vclr_q, ldoarst_q, rdata_q;
  logic [HALF_W-1:0] user0_q, user1_q;
  logic              load_pend_q, err_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .GROUPS(GROUPS), .PER_GROUP(PER_GROUP)) u_dec (
    .addr_i(addr_i), .sel_o(sel), .grp_o(grp), .idx_o(idx)
  );

  assign set_w = IRQ_W'(pll_evt) << PLL_BIT;

  sysctl_irq #(.W(IRQ_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mask_we_i(wr_i && sel == SEL_MASK), .clr_we_i(wr_i && sel == SEL_MIS),
    .wdata_i(wdata_i[IRQ_W-1:0]), .set_i(set_w),
    .raw_o(raw_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  sysctl_clkcfg #(.DW(DW), .SCALE_W(SCALE_W)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && sel == SEL_CLK),
    .wdata_i(wdata_i), .family_i(family_i),
    .cfg_o(cfg_w), .pll_o(pll_w), .scale_o(clk_scale_o), .pll_evt_o(pll_evt)
  );

  sysctl_gate_bank #(.GROUPS(GROUPS), .PER_GROUP(PER_GROUP), .DW(DW)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_i && sel == SEL_GATE),
    .grp_i(grp), .idx_i(idx), .wdata_i(wdata_i), .rdata_o(gate_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bor_q     <= BOR_RST;
      ldo_q     <= '0;
      rstc_q    <= '0;
      vclr_q    <= '0;
      ldoarst_q <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_BOR:     bor_q     <= wdata_i[BOR_W-1:0];
        SEL_LDO:     ldo_q     <= wdata_i[LDO_W-1:0];
        SEL_RSTC:    rstc_q    <= wdata_i[RSTC_W-1:0];
        SEL_VCLR:    vclr_q    <= wdata_i;
        SEL_LDOARST: ldoarst_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // user words are sampled once, on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_pend_q <= 1'b1;
      user0_q     <= '0;
      user1_q     <= '0;
    end else if (load_pend_q) begin
      load_pend_q <= 1'b0;
      user0_q     <= user_data_i[HALF_W-1:0];
      user1_q     <= user_data_i[USER_W-1:HALF_W];
    end
  end

  always_comb begin
    case (sel)
      SEL_BOR:     rd_val = DW'(bor_q);
      SEL_LDO:     rd_val = DW'(ldo_q);
      SEL_RAW:     rd_val = DW'(raw_w);
      SEL_MASK:    rd_val = DW'(mask_w);
      SEL_MIS:     rd_val = DW'(raw_w & mask_w);
      SEL_RSTC:    rd_val = DW'(rstc_q);
      SEL_CLK:     rd_val = cfg_w;
      SEL_PLL:     rd_val = pll_w;
      SEL_GATE:    rd_val = gate_rd;
      SEL_VCLR:    rd_val = vclr_q;
      SEL_LDOARST: rd_val = ldoarst_q;
      SEL_USER0:   rd_val = DW'(user0_q);
      SEL_USER1:   rd_val = DW'(user1_q);
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_val;
      err_q <= (rd_i | wr_i) && sel == SEL_NONE;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DW      = 32,
  parameter int unsigned IRQ_W   = 7,
  parameter int unsigned SCALE_W = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_i,
  input logic               rd_i,
  input logic [DW-1:0]      wdata_i,
  input logic               err_o,
  input logic               irq_o,
  input logic [SCALE_W-1:0] clk_scale_o,
  input logic [IRQ_W-1:0]   raw_i,
  input logic [IRQ_W-1:0]   mask_i,
  input logic               pwrdn_i
);
  logic [ADDR_W-3:0] word;
  assign word = addr_i[ADDR_W-1:2];

  p_pll_event_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word == (ADDR_W-2)'(10'h018) && pwrdn_i && !wdata_i[13]) |=> raw_i[6]);

  p_mis_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word == (ADDR_W-2)'(10'h016)) |=> ((raw_i & $past(wdata_i[IRQ_W-1:0])) == '0));

  p_mask_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word == (ADDR_W-2)'(10'h015)) |=> (mask_i == $past(wdata_i[IRQ_W-1:0])));

  p_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(raw_i & mask_i));

  p_scale_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && word == (ADDR_W-2)'(10'h018)) |=>
      (32'(clk_scale_o) == 5 * (32'($past(wdata_i[26:23])) + 1)));

  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_i | wr_i));
endmodule

bind sysctl_regs sysctl_checker #(.ADDR_W(ADDR_W), .DW(DW), .IRQ_W(IRQ_W), .SCALE_W(SCALE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .err_o(err_o), .irq_o(irq_o), .clk_scale_o(clk_scale_o),
  .raw_i(raw_w), .mask_i(mask_w), .pwrdn_i(cfg_w[13])
);

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0, wr_i = 0, rd_i = 0, family_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [47:0] user_data_i = 48'h665544_332211;
  logic [31:0] rdata_o;
  logic        err_o, irq_o;
  logic [6:0]  clk_scale_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysctl_regs u0 (.*);

  function automatic logic [31:0] exp_pll(input logic fam, input int i);
    if (!fam) return (((i + 1) * 3) << 5) | (i & 3);
    return ((i * 2 + 8) << 5) | ((i >> 2) & 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1;
    @(negedge clk_i); rd_i = 0; d = rdata_o;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
    check({req, " err"}, 32'(err_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] offs [15] = '{12'h030, 12'h034, 12'h05c, 12'h054, 12'h100, 12'h104, 12'h108,
                               12'h110, 12'h114, 12'h118, 12'h120, 12'h124, 12'h128, 12'h150, 12'h160};
    logic [31:0] msk  [15] = '{32'hffff, 32'h1f, 32'h3f, 32'h7f, '1, '1, '1, '1, '1, '1, '1, '1, '1, '1, '1};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    rdchk("R1 bor", 12'h030, 32'h7ffd);
    rdchk("R1 clkcfg", 12'h060, 32'h078e3ac0);
    rdchk("R1 run0", 12'h100, 1);
    rdchk("R1 sleep0", 12'h110, 1);
    rdchk("R1 deep0", 12'h120, 1);
    rdchk("R1 run2", 12'h108, 0);
    rdchk("R1 raw", 12'h050, 0);
    rdchk("R1 mis", 12'h058, 0);
    check("R7 reset scale", 32'(clk_scale_o), 80);

    // R9 user data, insensitive to later input and writes
    user_data_i = 48'hdead_beef_cafe;
    wr(12'h1e0, 32'hffffffff);
    rdchk("R9 user0", 12'h1e0, 32'h332211);
    rdchk("R9 user1", 12'h1e4, 32'h665544);

    // R4/R7/R8 keep bit13 high: no event
    wr(12'h060, (32'd3 << 23) | (32'd1 << 13) | (32'd5 << 6));
    check("R7 scale", 32'(clk_scale_o), 20);
    rdchk("R4 no event bit13 held", 12'h050, 0);
    rdchk("R8 pll fam0 i5", 12'h064, exp_pll(0, 5));
    family_i = 1;
    rdchk("R8 pll fam1 i5", 12'h064, exp_pll(1, 5));
    wr(12'h064, 32'h0);
    rdchk("R8 pll write ignored", 12'h064, exp_pll(1, 5));
    wr(12'h060, (32'd1 << 13) | (32'd15 << 6));
    check("R7 scale min", 32'(clk_scale_o), 5);
    rdchk("R8 pll fam1 i15", 12'h064, exp_pll(1, 15));
    family_i = 0;
    rdchk("R8 pll fam0 i15", 12'h064, exp_pll(0, 15));

    // R4 power-up event, R6 irq
    wr(12'h060, 32'd15 << 23);
    check("R7 scale max", 32'(clk_scale_o), 80);
    rdchk("R4 event raw", 12'h050, 32'h40);
    check("R6 masked off", 32'(irq_o), 0);
    rdchk("R5 mis masked off", 12'h058, 0);
    wr(12'h054, 32'hffffffc0);
    check("R6 irq after mask write", 32'(irq_o), 1);
    rdchk("R2 mask width", 12'h054, 32'h40);
    rdchk("R5 mis", 12'h058, 32'h40);
    wr(12'h050, 32'h0);
    rdchk("R5 raw write ignored", 12'h050, 32'h40);
    wr(12'h058, 32'h40);
    check("R6 irq after clear", 32'(irq_o), 0);
    rdchk("R5 raw cleared", 12'h050, 0);
    wr(12'h060, 32'h0);
    rdchk("R4 zero over zero", 12'h050, 0);
    check("R6 irq stays low", 32'(irq_o), 0);
    wr(12'h054, 32'h0);

    // R10/R3 unmapped and boundary offsets
    rd(12'h200, v);
    check("R10 unmapped rdata", v, 0);
    check("R10 unmapped err", 32'(err_o), 1);
    @(negedge clk_i);
    check("R10 err one cycle", 32'(err_o), 0);
    rd(12'h10c, v);
    check("R3 0x10c unmapped", 32'(err_o), 1);
    rd(12'h130, v);
    check("R3 0x130 unmapped", 32'(err_o), 1);
    wr(12'h03c, 32'h1234);
    check("R10 unmapped write err", 32'(err_o), 1);
    rdchk("R10 bor untouched", 12'h030, 32'h7ffd);
    check("R11 rdata holds", rdata_o, 32'h7ffd);

    // R2/R3 random writes with readback
    for (int n = 0; n < 60; n++) begin
      int k = int'($urandom_range(0, 14));
      logic [31:0] d = $urandom;
      wr(offs[k], d);
      rdchk(k >= 4 && k <= 12 ? "R3 gate rand" : "R2 rand", offs[k], d & msk[k]);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule